// File: doc/BRIEF.md
# Receive Label Match Filter

This block sits beside a serial word receiver and decides, for every incoming word, whether the word is kept or silently discarded. It holds a table of eight 8-bit label entries written by a host. The receiver presents the first byte of each word, which is the label, together with a one-cycle strobe. The filter compares that label against every entry at once and latches a keep or discard verdict. The verdict holds until the receiver signals the end of the word. A discarded word produces no ready indication and raises no error.

The host reaches the table through the same 8-bit data port it uses for the receiver. A command/data select line separates control-register writes from data transfers. Setting the filter bit of the control register from 0 to 1 starts a load sequence: the next eight data writes fill entries one to eight in order. Setting the read-back bit from 0 to 1 starts a read sequence: the next eight data reads return the entries in the same order. Filtering is active only while the feature-select input is high and the filter bit is set.

A rising edge on feature-select marks the table stale. Every word is discarded until a complete reload of all eight entries finishes. Unused slots must hold duplicate labels, because all slots always take part in the comparison.

Top module: `label_match_filter`

## Requirements
- R1: After reset, `ctrl_word` reads 8'b0010_0101 (bit 7 down to bit 0), both verdict outputs are low and `host_rdata` is zero.
- R2: A write with `host_cmd` high loads `host_wdata[7:0]` into `ctrl_word`, and the new value is visible one cycle after the write.
- R3: A control write that takes bit 7 (filter) from 0 to 1 arms a load. The next 8 data writes (`host_cmd` low) fill entries 1 to 8 in order. Data writes after the eighth do not change the table.
- R4: A control write that takes bit 1 (read-back) from 0 to 1 arms one read sequence. While it is armed, `host_rdata` shows the next entry, and each data read strobe advances to the following entry, from entry 1 to entry 8. Once the 8 reads are done, `host_rdata` is zero. A control write that leaves bit 1 at 1 does not re-arm the sequence.
- R5: When filtering is active and the table is complete, a label equal to any entry (including entry 8) sets `word_pass` high and `word_drop` low in the cycle after `rx_label_vld`.
- R6: When filtering is active, a label that matches no entry sets `word_drop` high and `word_pass` low. `word_pass` and `word_drop` are never high together.
- R7: While `feat_sel` is low or bit 7 is 0, every word gets `word_pass`, whatever its label.
- R8: The table counts as stale after reset, after a load is armed, and after a rising edge of `feat_sel`. While the table is stale and filtering is active, every word is dropped. The table stops being stale only when all 8 data writes of a load have finished.
- R9: The verdict is held while `rx_label` changes, until `rx_word_end`. Both verdict outputs are low in the cycle after `rx_word_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe, one cycle per transfer |
| host_rd | input | 1 | Host read strobe, one cycle per transfer |
| host_cmd | input | 1 | 1 = control register, 0 = data |
| host_wdata | input | LBL_W | Host write data |
| host_rdata | output | LBL_W | Table entry returned during a read-back sequence, else zero |
| ctrl_word | output | 8 | Control register (bit 7 filter, bit 1 read-back) |
| feat_sel | input | 1 | Feature-select; filtering is possible only while high |
| rx_label | input | LBL_W | Label byte of the current word |
| rx_label_vld | input | 1 | Label complete strobe |
| rx_word_end | input | 1 | End-of-word strobe, releases the verdict |
| word_pass | output | 1 | Current word is kept |
| word_drop | output | 1 | Current word is discarded |

## Verification
The bench builds the block with its default values: eight entries of eight bits. At this size the full load and read-back sequences run end to end, including the ninth write and the ninth read past their ends, and a match against the last slot proves that every entry is compared. A word sent halfway through a load, and a word sent after `feat_sel` rises, cover the stale-table rule. A scoreboard queue checks each verdict against the label that was sent.

// File: rtl/lmf_pkg.sv
`timescale 1ns/1ps
package lmf_pkg;
   localparam int CTRL_W          = 8;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 8'b0010_0101;
   localparam int BIT_FILTER      = 7;
   localparam int BIT_READBACK    = 1;
endpackage

// File: rtl/lmf_label_table.sv
`timescale 1ns/1ps
module lmf_label_table #(
   parameter int N = 8,
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           arm_load,
   input  logic           arm_read,
   input  logic           wr_data,
   input  logic [W-1:0]   wr_val,
   input  logic           rd_data,
   input  logic           stale,
   output logic [N*W-1:0] entries,
   output logic [W-1:0]   rd_val,
   output logic           tbl_ok
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;
   localparam int CW = $clog2(N + 1);

   generate
      if (N < 1 || W < 1) begin : g_bad
         $error("lmf_label_table: N and W must be positive");
      end
   endgenerate

   logic [W-1:0]  ent [N];
   logic [CW-1:0] ld_left, rd_left;
   logic [IW-1:0] ld_idx, rd_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) ent[i] <= '0;
         ld_left <= '0;
         ld_idx  <= '0;
         tbl_ok  <= 1'b0;
      end else begin
         if (arm_load) begin
            ld_left <= CW'(N);
            ld_idx  <= '0;
            tbl_ok  <= 1'b0;
         end else if (wr_data && ld_left != '0) begin
            ent[ld_idx] <= wr_val;
            ld_idx      <= ld_idx + IW'(1);
            ld_left     <= ld_left - CW'(1);
            if (ld_left == CW'(1)) tbl_ok <= 1'b1;
         end
         if (stale) tbl_ok <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_left <= '0;
         rd_idx  <= '0;
      end else if (arm_read) begin
         rd_left <= CW'(N);
         rd_idx  <= '0;
      end else if (rd_data && rd_left != '0) begin
         rd_left <= rd_left - CW'(1);
         rd_idx  <= rd_idx + IW'(1);
      end
   end

   assign rd_val = (rd_left != '0) ? ent[rd_idx] : '0;

   generate
      for (genvar g = 0; g < N; g++) begin : g_flat
         assign entries[g*W +: W] = ent[g];
      end
   endgenerate

   // R3: a pending load sequence advances only on data writes
   a_r3_load_waits: assert property (@(posedge clk) disable iff (rst)
      (ld_left != '0 && !wr_data && !arm_load) |=> $stable(ld_left));
   // R4: each read strobe during a sequence consumes exactly one entry
   a_r4_read_steps: assert property (@(posedge clk) disable iff (rst)
      (rd_data && rd_left != '0 && !arm_read) |=> (rd_left == $past(rd_left) - CW'(1)));
   // R8: a feature-select rising edge invalidates the table
   a_r8_stale_clears: assert property (@(posedge clk) disable iff (rst)
      stale |=> !tbl_ok);
endmodule

// File: rtl/lmf_label_cmp.sv
`timescale 1ns/1ps
module lmf_label_cmp #(
   parameter int N = 8,
   parameter int W = 8
) (
   input  logic [N*W-1:0] entries,
   input  logic [W-1:0]   probe,
   output logic           hit
);
   logic [N-1:0] hits;

   generate
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign hits[g] = (entries[g*W +: W] == probe);
      end
   endgenerate

   assign hit = |hits;
endmodule

// File: rtl/label_match_filter.sv
`timescale 1ns/1ps
module label_match_filter
   import lmf_pkg::*;
#(
   parameter int N_LABELS = 8,
   parameter int LBL_W    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_cmd,
   input  logic [LBL_W-1:0]  host_wdata,
   output logic [LBL_W-1:0]  host_rdata,
   output logic [CTRL_W-1:0] ctrl_word,
   input  logic              feat_sel,
   input  logic [LBL_W-1:0]  rx_label,
   input  logic              rx_label_vld,
   input  logic              rx_word_end,
   output logic              word_pass,
   output logic              word_drop
);
   generate
      if (LBL_W < CTRL_W) begin : g_bad_w
         $error("label_match_filter: LBL_W must cover the control word");
      end
      if (N_LABELS < 1) begin : g_bad_n
         $error("label_match_filter: N_LABELS must be positive");
      end
   endgenerate

   logic ctrl_wr, data_wr, data_rd, arm_load, arm_read;
   logic feat_q, stale, filt_en, tbl_ok, hit;
   logic [N_LABELS*LBL_W-1:0] entries;

   assign ctrl_wr  = host_wr & host_cmd;
   assign data_wr  = host_wr & ~host_cmd;
   assign data_rd  = host_rd & ~host_cmd;
   assign arm_load = ctrl_wr & ~ctrl_word[BIT_FILTER]   & host_wdata[BIT_FILTER];
   assign arm_read = ctrl_wr & ~ctrl_word[BIT_READBACK] & host_wdata[BIT_READBACK];
   assign stale    = feat_sel & ~feat_q;
   assign filt_en  = feat_sel & ctrl_word[BIT_FILTER];

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_word <= CTRL_RESET;
         feat_q    <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_word <= host_wdata[CTRL_W-1:0];
         feat_q <= feat_sel;
      end
   end

   lmf_label_table #(.N(N_LABELS), .W(LBL_W)) u_table (
      .clk      (clk),
      .rst      (rst),
      .arm_load (arm_load),
      .arm_read (arm_read),
      .wr_data  (data_wr),
      .wr_val   (host_wdata),
      .rd_data  (data_rd),
      .stale    (stale),
      .entries  (entries),
      .rd_val   (host_rdata),
      .tbl_ok   (tbl_ok)
   );

   lmf_label_cmp #(.N(N_LABELS), .W(LBL_W)) u_cmp (
      .entries (entries),
      .probe   (rx_label),
      .hit     (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         word_pass <= 1'b0;
         word_drop <= 1'b0;
      end else if (rx_label_vld) begin
         word_pass <= ~filt_en | (tbl_ok & hit);
         word_drop <= filt_en & ~(tbl_ok & hit);
      end else if (rx_word_end) begin
         word_pass <= 1'b0;
         word_drop <= 1'b0;
      end
   end

   // R6: the two verdicts exclude each other
   a_r6_verdict_excl: assert property (@(posedge clk) disable iff (rst)
      !(word_pass && word_drop));
   // R9: a kept word stays kept until its end
   a_r9_verdict_hold: assert property (@(posedge clk) disable iff (rst)
      (word_pass && !rx_label_vld && !rx_word_end) |=> word_pass);
   // R7: without active filtering every word is kept
   a_r7_open_pass: assert property (@(posedge clk) disable iff (rst)
      (rx_label_vld && !(feat_sel && ctrl_word[BIT_FILTER])) |=> word_pass);
   // R2: control writes land in the control register
   a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_cmd) |=> (ctrl_word == $past(host_wdata[CTRL_W-1:0])));
endmodule

// File: tb/label_match_filter_bench.sv
`timescale 1ns/1ps
module label_match_filter_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic host_wr = 1'b0, host_rd = 1'b0, host_cmd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [7:0] ctrl_word;
   logic feat_sel = 1'b0;
   logic [7:0] rx_label = '0;
   logic rx_label_vld = 1'b0, rx_word_end = 1'b0;
   logic word_pass, word_drop;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic exp_q [$];
   logic seen = 1'b0;
   logic [7:0] lbls [8];

   always #4 clk = ~clk;

   label_match_filter u_label_match_filter (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
      .host_cmd(host_cmd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ctrl_word(ctrl_word), .feat_sel(feat_sel), .rx_label(rx_label),
      .rx_label_vld(rx_label_vld), .rx_word_end(rx_word_end),
      .word_pass(word_pass), .word_drop(word_drop)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic cmd, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_cmd = cmd; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_cmd = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] exp);
      @(negedge clk);
      chk(tag, host_rdata, exp);
      host_rd = 1'b1; host_cmd = 1'b0;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic load_all();
      for (int i = 0; i < 8; i++) wr(1'b0, lbls[i]);
   endtask

   // driver: pushes the expected verdict, the monitor pops it
   task automatic send_word(input string tag, input logic [7:0] lbl, input logic keep);
      @(negedge clk);
      rx_label = lbl; rx_label_vld = 1'b1;
      exp_q.push_back(keep);
      @(negedge clk);
      rx_label_vld = 1'b0; rx_label = ~lbl;
      repeat (3) @(negedge clk);
      chk({tag, " R9 hold"}, {word_pass, word_drop}, {keep, ~keep});
      rx_word_end = 1'b1;
      @(negedge clk);
      rx_word_end = 1'b0;
      chk({tag, " R9 release"}, {word_pass, word_drop}, 2'b00);
   endtask

   always @(posedge clk) seen <= rx_label_vld;

   always @(negedge clk) begin
      if (seen) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: verdict with nothing expected, actual %b%b expected none",
                     word_pass, word_drop);
         end else begin
            logic e;
            e = exp_q.pop_front();
            if (word_pass !== e || word_drop !== ~e) begin
               n_fail++;
               $display("FAIL scoreboard R5/R6/R7/R8: actual pass=%b drop=%b expected pass=%b drop=%b",
                        word_pass, word_drop, e, ~e);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      lbls = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctrl", ctrl_word, 8'h25);
      chk("R1 verdict", {word_pass, word_drop}, 2'b00);
      chk("R1 rdata", host_rdata, 8'h00);

      // R7 filter bit clear, feature-select low
      send_word("R7 open", 8'h99, 1'b1);
      feat_sel = 1'b1;
      send_word("R7 filter bit clear", 8'h99, 1'b1);

      // R2 / R3 arm load
      wr(1'b1, 8'hA5);
      chk("R2 ctrl write", ctrl_word, 8'hA5);
      for (int i = 0; i < 4; i++) wr(1'b0, lbls[i]);
      send_word("R8 partial table", 8'h11, 1'b0);
      for (int i = 4; i < 8; i++) wr(1'b0, lbls[i]);
      wr(1'b0, 8'hEE);   // R3 ninth write ignored

      // R4 read-back
      wr(1'b1, 8'hA7);
      for (int i = 0; i < 8; i++) rd("R4/R3 readback", lbls[i]);
      rd("R4 after sequence", 8'h00);
      wr(1'b1, 8'hA7);
      rd("R4 no rearm", 8'h00);

      // R5 / R6 filtering
      send_word("R5 first entry", 8'h11, 1'b1);
      send_word("R5 last entry", 8'h88, 1'b1);
      send_word("R6 no match", 8'h99, 1'b0);
      send_word("R6 near miss", 8'h12, 1'b0);

      // R8 feature-select rise
      feat_sel = 1'b0;
      send_word("R7 feat low", 8'h99, 1'b1);
      feat_sel = 1'b1;
      send_word("R8 stale after rise", 8'h11, 1'b0);
      wr(1'b1, 8'h25);
      wr(1'b1, 8'hA5);
      load_all();
      send_word("R8 reloaded", 8'h44, 1'b1);
      wr(1'b1, 8'h27);
      chk("R2 ctrl filter off", ctrl_word, 8'h27);
      send_word("R7 filter bit cleared", 8'h99, 1'b1);

      repeat (2) @(negedge clk);
      chk("scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule